// File: doc/BRIEF.md
# Three-Channel Match Timer with Snapshot Capture

This peripheral holds three free-running 32-bit up-counters. Each counter has three match comparators, a preload value and a reload-select mask. While a counter is enabled it advances by one per clock. When its value equals a comparator chosen in the reload-select mask, it loads the preload value instead. With a comparator at 0xFFFFFFFF and a preload of zero, a counter sweeps the full 32-bit range.

Every comparator hit sets a sticky status bit. Software clears status bits by writing ones. A per-timer interrupt line is raised while any status bit and its enable are both set. Software never reads a running counter directly. It writes a request to the timer's snapshot register, waits while a busy flag is set, and then reads the frozen value from the same address. This avoids reading a count that is still changing.

A plain word-addressed write/read port with a read-valid flag gives access to all state.

Top module: `match_timer_top`

## Requirements
- R1: After reset, every counter, status bit, enable bit, busy flag, snapshot value and interrupt line reads as 0.
- R2: The enable register at address 0x00 holds one bit per timer, with bit t for timer t. A timer whose bit is 1 increments by one each clock. A timer whose bit is 0 holds its value and resumes from it when enabled again.
- R3: The reload-select register (timer offset 1) holds one bit per comparator. If an enabled counter equals comparator c and reload-select bit c is 1, the next value is the preload (offset 0). Otherwise the counter wraps modulo 2^32.
- R4: A status bit c (offset 2, bit c) is set in every cycle in which the enabled counter equals comparator c, whatever the reload-select setting. It stays set until it is cleared.
- R5: Writing to the clear register (offset 4) clears exactly the status bits written as 1. A hit in the same cycle wins over the clear.
- R6: irq[t] is 1 exactly when status and interrupt enable (offset 3) share a set bit. With the enable at 0, irq[t] stays 0.
- R7: Writing a value with bit 0 = 1 to the snapshot register (offset 5) sets busy bit t at address 0x01 for exactly two cycles. The snapshot then holds the counter value, and a read of offset 5 returns it. A write with bit 0 = 0, or a request made while busy, has no effect.
- R8: A read returns data with rd_valid high in the next cycle. Comparator c of timer t sits at address 2 + 3t + c and reads back as written. The per-timer registers sit at 0x10 + 8t + offset and read back as written.
- R9: Writes to one timer's registers leave the other timers' counters and status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq | output | 3 | Per-timer interrupt lines |

## Verification
The bench steps a reference model through every enabled cycle. It covers reload at a comparator placed just past the current value, a reload into the top of the range followed by a full wrap, and a sweep of run lengths across a short reload loop. A design that reloads one cycle late, or that compares against the next value, drifts from the model within a few runs. The bench reads the busy flag once in the middle of a snapshot and once after it. A snapshot that latches too early, too late or never shows up either as a wrong busy readback or as a stale captured value. It also checks that clearing one status bit leaves its neighbours set and that a masked interrupt stays low, which catches clear logic that wipes the whole register.

// File: rtl/mt_pkg.sv
// Package: address map shared by the match timer and its bench-visible checker.
// Assumes word addressing; per-timer blocks are spaced A_TSTRIDE words apart.
package mt_pkg;
    localparam int A_CEN     = 0;
    localparam int A_BUSY    = 1;
    localparam int A_MATCH   = 2;
    localparam int A_TBASE   = 16;
    localparam int A_TSTRIDE = 8;
    localparam int O_PRE     = 0;
    localparam int O_PCTL    = 1;
    localparam int O_STS     = 2;
    localparam int O_IE      = 3;
    localparam int O_CLR     = 4;
    localparam int O_CAP     = 5;

    // Word address of a per-timer register.
    function automatic int tmr_addr(input int t, input int off);
        return A_TBASE + t * A_TSTRIDE + off;
    endfunction

    // Word address of comparator c of timer t.
    function automatic int match_addr(input int t, input int c, input int ncmp);
        return A_MATCH + t * ncmp + c;
    endfunction
endpackage

// File: rtl/mt_channel.sv
// Module: one counter with NUM_CMP comparators, sticky status and an interrupt.
// Assumes match, preload, reload-select and enable are held stable by the register block.
module mt_channel #(
    parameter int CNT_W   = 32,
    parameter int NUM_CMP = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   match_i,
    input  logic [CNT_W-1:0]                preload_i,
    input  logic [NUM_CMP-1:0]              pctrl_i,
    input  logic [NUM_CMP-1:0]              clr_i,
    input  logic [NUM_CMP-1:0]              ie_i,
    output logic [CNT_W-1:0]                cnt_o,
    output logic [NUM_CMP-1:0]              sts_o,
    output logic                            irq_o
);
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_CMP-1:0] sts_q;
    logic [NUM_CMP-1:0] hit;
    logic               reload;

    // One equality comparator per match register, active only while counting.
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        assign hit[c] = en && (cnt_q == match_i[c]);
    end

    assign reload = |(hit & pctrl_i);

    // Counter: advance or reload while enabled, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en)
            cnt_q <= reload ? preload_i : cnt_q + CNT_W'(1);
    end

    // Status: write-one clear, hits take priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~clr_i) | hit;
    end

    assign cnt_o = cnt_q;
    assign sts_o = sts_q;
    assign irq_o = |(sts_q & ie_i);
endmodule

// File: rtl/mt_capture.sv
// Module: snapshot of a counter taken STAGES cycles after a request.
// Assumes STAGES >= 2; requests arriving while busy are dropped.
module mt_capture #(
    parameter int CNT_W  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] val_o
);
    logic [STAGES-1:0] pipe_q;
    logic [CNT_W-1:0]  val_q;
    logic              take;

    assign busy_o = |pipe_q;
    assign take   = req && !busy_o;

    // Request travels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= {pipe_q[STAGES-2:0], take};
    end

    // Latch the counter when the request leaves the chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else if (pipe_q[STAGES-1])
            val_q <= cnt_i;
    end

    assign val_o = val_q;
endmodule

// File: rtl/match_timer_top.sv
// Module: register block and NUM_TMR channels of the match timer.
// Assumes one access per cycle; writes take effect at the clock edge that samples them.
module match_timer_top #(
    parameter int NUM_TMR = 3,
    parameter int NUM_CMP = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    output logic               rd_valid,
    output logic [NUM_TMR-1:0] irq
);
    import mt_pkg::*;

    logic [NUM_TMR-1:0]                            cen_q;
    logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0]    match_q;
    logic [NUM_TMR-1:0][CNT_W-1:0]                 pre_q;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]               pctl_q;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]               ie_q;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]               clr_s;
    logic [NUM_TMR-1:0]                            capreq_s;
    logic [NUM_TMR-1:0][CNT_W-1:0]                 cnt_all;
    logic [NUM_TMR-1:0][CNT_W-1:0]                 cap_all;
    logic [NUM_TMR-1:0][NUM_CMP-1:0]               sts_all;
    logic [NUM_TMR-1:0]                            busy_all;
    logic [CNT_W-1:0]                              rd_d;

    // Configuration registers: decode writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q   <= '0;
            match_q <= '0;
            pre_q   <= '0;
            pctl_q  <= '0;
            ie_q    <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_CEN))
                cen_q <= wdata[NUM_TMR-1:0];
            for (int t = 0; t < NUM_TMR; t++) begin
                for (int c = 0; c < NUM_CMP; c++)
                    if (addr == ADDR_W'(match_addr(t, c, NUM_CMP)))
                        match_q[t][c] <= wdata;
                if (addr == ADDR_W'(tmr_addr(t, O_PRE)))
                    pre_q[t] <= wdata;
                if (addr == ADDR_W'(tmr_addr(t, O_PCTL)))
                    pctl_q[t] <= wdata[NUM_CMP-1:0];
                if (addr == ADDR_W'(tmr_addr(t, O_IE)))
                    ie_q[t] <= wdata[NUM_CMP-1:0];
            end
        end
    end

    // Write strobes for status clear and snapshot request.
    always_comb begin
        for (int t = 0; t < NUM_TMR; t++) begin
            clr_s[t]    = (wr_en && addr == ADDR_W'(tmr_addr(t, O_CLR))) ?
                          wdata[NUM_CMP-1:0] : '0;
            capreq_s[t] = wr_en && addr == ADDR_W'(tmr_addr(t, O_CAP)) && wdata[0];
        end
    end

    // One counter channel and one snapshot unit per timer.
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        mt_channel #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (cen_q[t]),
            .match_i   (match_q[t]),
            .preload_i (pre_q[t]),
            .pctrl_i   (pctl_q[t]),
            .clr_i     (clr_s[t]),
            .ie_i      (ie_q[t]),
            .cnt_o     (cnt_all[t]),
            .sts_o     (sts_all[t]),
            .irq_o     (irq[t])
        );
        mt_capture #(.CNT_W(CNT_W), .STAGES(STAGES)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (capreq_s[t]),
            .cnt_i  (cnt_all[t]),
            .busy_o (busy_all[t]),
            .val_o  (cap_all[t])
        );
    end

    // Read multiplexer: select the addressed register.
    always_comb begin
        rd_d = '0;
        if (addr == ADDR_W'(A_CEN))
            rd_d = CNT_W'(cen_q);
        if (addr == ADDR_W'(A_BUSY))
            rd_d = CNT_W'(busy_all);
        for (int t = 0; t < NUM_TMR; t++) begin
            for (int c = 0; c < NUM_CMP; c++)
                if (addr == ADDR_W'(match_addr(t, c, NUM_CMP)))
                    rd_d = match_q[t][c];
            if (addr == ADDR_W'(tmr_addr(t, O_PRE)))  rd_d = pre_q[t];
            if (addr == ADDR_W'(tmr_addr(t, O_PCTL))) rd_d = CNT_W'(pctl_q[t]);
            if (addr == ADDR_W'(tmr_addr(t, O_STS)))  rd_d = CNT_W'(sts_all[t]);
            if (addr == ADDR_W'(tmr_addr(t, O_IE)))   rd_d = CNT_W'(ie_q[t]);
            if (addr == ADDR_W'(tmr_addr(t, O_CAP)))  rd_d = cap_all[t];
        end
    end

    // Registered read port with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (rd_en)
                rdata <= rd_d;
            rd_valid <= rd_en;
        end
    end
endmodule

// File: rtl/mt_checker.sv
// Module: temporal checks on the match timer, attached by bind.
// Assumes the default two-stage snapshot chain for the busy-length check.
module mt_checker #(
    parameter int NUM_TMR = 3,
    parameter int NUM_CMP = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     wr_en,
    input logic                                     rd_en,
    input logic [ADDR_W-1:0]                        addr,
    input logic                                     rd_valid,
    input logic [NUM_TMR-1:0]                       irq,
    input logic [NUM_TMR-1:0]                       cen,
    input logic [NUM_TMR-1:0][CNT_W-1:0]            cnt,
    input logic [NUM_TMR-1:0][NUM_CMP-1:0]          sts,
    input logic [NUM_TMR-1:0][NUM_CMP-1:0]          ie,
    input logic [NUM_TMR-1:0]                       busy,
    input logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0] match,
    input logic [NUM_TMR-1:0][NUM_CMP-1:0]          pctrl,
    input logic [NUM_TMR-1:0][CNT_W-1:0]            preload
);
    import mt_pkg::*;

    // A read strobe is answered in the next cycle, and only then (R8).
    a_r8_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
        logic rl;
        always_comb begin
            rl = 1'b0;
            for (int c = 0; c < NUM_CMP; c++)
                if (pctrl[t][c] && cnt[t] == match[t][c]) rl = 1'b1;
        end

        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !cen[t] |=> cnt[t] == $past(cnt[t]));
        a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
            (cen[t] && !rl) |=> cnt[t] == $past(cnt[t]) + CNT_W'(1));
        a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
            (cen[t] && rl) |=> cnt[t] == $past(preload[t]));
        a_r5_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(sts[t]) & ~sts[t]) != '0) |->
                ($past(wr_en) && $past(addr) == ADDR_W'(tmr_addr(t, O_CLR))));
        a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
            (ie[t] == '0) |-> !irq[t]);
        a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[t]) |=> busy[t] ##1 !busy[t]);
    end
endmodule

bind match_timer_top mt_checker #(
    .NUM_TMR(NUM_TMR), .NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .rd_valid(rd_valid), .irq(irq), .cen(cen_q), .cnt(cnt_all), .sts(sts_all),
    .ie(ie_q), .busy(busy_all), .match(match_q), .pctrl(pctl_q), .preload(pre_q)
);

// File: tb/tb_match_timer_top.sv
`timescale 1ns/1ps
// Bench: drives the register port and compares against a cycle-stepped model.
module tb_match_timer_top;
    import mt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid;
    logic [2:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_match [3][3];
    logic [31:0] m_pre [3];
    logic [2:0]  m_pctl [3];
    logic [2:0]  m_sts [3];
    logic [31:0] m_cnt [3];

    match_timer_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 8'(a);
        @(negedge clk);
        rd_en = 1'b0;
        if (!rd_valid) begin
            failures++;
            $display("FAIL R8 rd_valid actual=0 expected=1");
        end
        d = rdata;
    endtask

    task automatic wr_match(input int t, input int c, input logic [31:0] v);
        wr(match_addr(t, c, 3), v);
        m_match[t][c] = v;
    endtask

    // Model: apply n enabled cycles to timer t.
    task automatic model_run(input int t, input int n);
        for (int i = 0; i < n; i++) begin
            logic rl;
            rl = 1'b0;
            for (int c = 0; c < 3; c++)
                if (m_cnt[t] == m_match[t][c]) begin
                    m_sts[t][c] = 1'b1;
                    if (m_pctl[t][c]) rl = 1'b1;
                end
            m_cnt[t] = rl ? m_pre[t] : m_cnt[t] + 32'd1;
        end
    endtask

    // Enable timer t for exactly k+2 cycles, then stop it.
    task automatic run(input int t, input int k);
        wr(A_CEN, 32'(1 << t));
        repeat (k) @(negedge clk);
        wr(A_CEN, 32'd0);
        model_run(t, k + 2);
    endtask

    task automatic snap(input int t, output logic [31:0] v);
        logic [31:0] b;
        wr(tmr_addr(t, O_CAP), 32'd1);
        repeat (3) @(negedge clk);
        rd(A_BUSY, b);
        rd(tmr_addr(t, O_CAP), v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        for (int t = 0; t < 3; t++) begin
            m_pre[t] = '0; m_pctl[t] = '0; m_sts[t] = '0; m_cnt[t] = '0;
            for (int c = 0; c < 3; c++) m_match[t][c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CEN, v);  chk("R1 enable", v, 0);
        rd(A_BUSY, v); chk("R1 busy", v, 0);
        chk("R1 irq", 32'(irq), 0);
        for (int t = 0; t < 3; t++) begin
            rd(tmr_addr(t, O_STS), v); chk("R1 status", v, 0);
            rd(tmr_addr(t, O_CAP), v); chk("R1 snapshot", v, 0);
        end

        // R8: readback sweep over comparators and per-timer registers
        for (int t = 0; t < 3; t++)
            for (int c = 0; c < 3; c++)
                wr_match(t, c, 32'h4000_0000 + 32'(t * 16 + c));
        for (int t = 0; t < 3; t++)
            for (int c = 0; c < 3; c++) begin
                rd(match_addr(t, c, 3), v);
                chk("R8 match readback", v, 32'h4000_0000 + 32'(t * 16 + c));
            end
        for (int t = 0; t < 3; t++) begin
            wr(tmr_addr(t, O_PRE), 32'hA500 + 32'(t));
            wr(tmr_addr(t, O_PCTL), 32'(t + 4));
            wr(tmr_addr(t, O_IE), 32'(t + 1));
        end
        for (int t = 0; t < 3; t++) begin
            rd(tmr_addr(t, O_PRE), v);  chk("R8 preload readback", v, 32'hA500 + 32'(t));
            rd(tmr_addr(t, O_PCTL), v); chk("R8 reload-select readback", v, 32'(t + 4));
            rd(tmr_addr(t, O_IE), v);   chk("R8 ie readback", v, 32'(t + 1));
            wr(tmr_addr(t, O_PCTL), 32'd0);
            wr(tmr_addr(t, O_IE), 32'd0);
            wr(tmr_addr(t, O_PRE), 32'd0);
        end

        // R2: counting and hold
        run(0, 5);
        snap(0, v); chk("R2 count after run", v, m_cnt[0]);
        repeat (10) @(negedge clk);
        snap(0, v2); chk("R2 hold while disabled", v2, m_cnt[0]);
        run(0, 0);
        snap(0, v); chk("R2 resume from held value", v, m_cnt[0]);

        // R9: other timers untouched
        snap(1, v); chk("R9 timer1 idle", v, 0);
        snap(2, v); chk("R9 timer2 idle", v, 0);
        rd(tmr_addr(1, O_STS), v); chk("R9 timer1 status", v, 0);

        // R7: busy timing and ignored request
        wr(tmr_addr(1, O_CAP), 32'd1);
        rd(A_BUSY, v); chk("R7 busy during snapshot", v, 32'h2);
        rd(A_BUSY, v); chk("R7 busy cleared", v, 0);
        wr(tmr_addr(1, O_CAP), 32'd2);
        rd(A_BUSY, v); chk("R7 request bit0=0 ignored", v, 0);

        // R3: sweep of run lengths across a reload loop on timer 2
        wr_match(2, 0, 32'd9);
        wr(tmr_addr(2, O_PRE), 32'd3);  m_pre[2] = 32'd3;
        wr(tmr_addr(2, O_PCTL), 32'd1); m_pctl[2] = 3'd1;
        for (int k = 0; k < 11; k++) begin
            run(2, k);
            snap(2, v); chk("R3 reload loop", v, m_cnt[2]);
        end

        // R3: reload to the top of the range, then full-range wrap on timer 1
        wr_match(1, 1, m_cnt[1] + 32'd2);
        wr(tmr_addr(1, O_PRE), 32'hFFFF_FFFC);  m_pre[1] = 32'hFFFF_FFFC;
        wr(tmr_addr(1, O_PCTL), 32'd2);         m_pctl[1] = 3'd2;
        run(1, 3);
        snap(1, v); chk("R3 reload to top", v, 32'hFFFF_FFFE);
        wr_match(1, 0, 32'hFFFF_FFFF);
        wr(tmr_addr(1, O_PRE), 32'd0);   m_pre[1] = 32'd0;
        wr(tmr_addr(1, O_PCTL), 32'd1);  m_pctl[1] = 3'd1;
        run(1, 2);
        snap(1, v); chk("R3 full-range wrap", v, 32'd2);

        // R4: status against model for all timers
        for (int t = 0; t < 3; t++) begin
            rd(tmr_addr(t, O_STS), v); chk("R4 status", v, 32'(m_sts[t]));
        end

        // R6: interrupt masking
        chk("R6 irq masked", 32'(irq), 0);
        wr(tmr_addr(1, O_IE), 32'h7);
        @(negedge clk);
        chk("R6 irq timer1", 32'(irq), 32'h2);
        wr(tmr_addr(1, O_IE), 32'h1);
        @(negedge clk);
        chk("R6 irq by bit0 only", 32'(irq[1]), 32'(m_sts[1][0]));

        // R5: selective clear
        wr(tmr_addr(1, O_CLR), 32'h1); m_sts[1][0] = 1'b0;
        rd(tmr_addr(1, O_STS), v); chk("R5 clear bit0 only", v, 32'(m_sts[1]));
        chk("R6 irq after clear", 32'(irq), 0);
        wr(tmr_addr(1, O_CLR), 32'h7); m_sts[1] = '0;
        rd(tmr_addr(1, O_STS), v); chk("R5 clear all", v, 0);
        rd(tmr_addr(2, O_STS), v); chk("R9 timer2 status kept", v, 32'(m_sts[2]));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule